// File: doc/BRIEF.md
# Two-Lane Mutually Clocked Keystream Generator

This block is the state engine of a binary additive stream cipher. It holds two 160-bit registers: a linear register whose update is a controlled Galois-style shift, and a nonlinear register whose update mixes neighbouring bits through fixed masks. The update of each register is steered by a control bit. That control bit is taken from bits of both registers, so each register decides how the other one moves.

Software-independent sequencing logic outside the block first loads both registers. It then steps the block in initialisation mode while it feeds key and IV material through the `mix` and `in_bit` inputs, one generator step per cycle. After that it switches the block to run mode. In run mode the two unrolled step stages advance the state twice per enabled cycle, and the block delivers two keystream bits per cycle with a valid flag. The user XORs these bits onto the data stream.

Top module: `kg2_core`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `ks` is 0 and `ks_valid` is 0.
- R2: When `load` is high at a clock edge, the linear register takes `r_load` and the nonlinear register takes `s_load`. This holds whatever the values of `en` and `init_mode` are, and `ks_valid` is 0 in the following cycle.
- R3: One step of the linear register produces R' = (R<<1), XORed with the tap mask when R[159] XOR ir is 1, and XORed with the old R when its control bit is 1.
- R4: One step of the nonlinear register produces S'[159]=S[158] and S'[0]=0. Bits 1..158 are (S<<1) XOR ((S XOR C0) AND ((S>>1) XOR C1)). The result is then XORed with FB1 when the control bit is 1, or FB0 when it is 0, if S[159] XOR is is 1.
- R5: The linear control bit is S[54] XOR R[106]. The nonlinear control bit is S[106] XOR R[53].
- R6: With `en`=1 and `init_mode`=1, the block performs exactly one step per cycle with ir = in_bit XOR (S[80] AND mix) and is = in_bit, and `ks_valid` is 0 in the following cycle.
- R7: With `en`=1 and `init_mode`=0, the block performs two steps per cycle, and `mix` and `in_bit` have no effect (both taken as 0).
- R8: Each step's keystream bit is R[0] XOR S[0] of the state before that step. `ks[0]` carries the first step of the cycle and `ks[1]` carries the second.
- R9: `ks_valid` is 1 in the cycle after an enabled run-mode cycle with `load` low, and 0 otherwise.
- R10: With `en`=0 and `load`=0, both registers hold their values and `ks_valid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the generator this cycle |
| init_mode | input | 1 | 1: one initialisation step; 0: two keystream steps |
| mix | input | 1 | Mix control for initialisation |
| in_bit | input | 1 | Input bit for initialisation |
| load | input | 1 | Write both registers from the load buses |
| r_load | input | 160 | Load value for the linear register |
| s_load | input | 160 | Load value for the nonlinear register |
| ks | output | 2 | Keystream bits, bit 0 earliest |
| ks_valid | output | 1 | ks holds fresh bits from the last cycle |

## Verification
The two functions that can fall in the same cycle are a state load and an enabled keystream step. The bench provokes this by raising `load` while `en` is high in run mode. It judges the outcome by a low `ks_valid` in the next cycle and by a following keystream that matches, bit for bit, a one-step-at-a-time reference started from the loaded values. The same reference also covers the interleaving of initialisation steps with the mix and input bits toggling, and the ignored inputs during run mode.

// File: rtl/kg_pkg.sv
package kg_pkg;

    localparam int KG_W = 160;

    // bit positions whose meaning the control and feed logic depends on
    localparam int R_CTL_RBIT = 106;
    localparam int R_CTL_SBIT = 54;
    localparam int S_CTL_SBIT = 106;
    localparam int S_CTL_RBIT = 53;
    localparam int MIX_SBIT   = 80;
    localparam int TOP_BIT    = KG_W - 1;
    localparam int NEXT_BIT   = KG_W - 2;

    typedef logic [KG_W-1:0] kg_vec_t;

    typedef struct packed {
        kg_vec_t r;
        kg_vec_t s;
    } kg_state_t;

    typedef enum logic {
        KG_RUN  = 1'b0,
        KG_INIT = 1'b1
    } kg_mode_e;

    // computed fixed-pattern generator for the constant masks
    function automatic kg_vec_t kg_pattern(input int mul, input int add, input int modv);
        kg_vec_t v;
        for (int i = 0; i < KG_W; i++) begin
            v[i] = (((i * mul) + add) % modv) < (modv / 2);
        end
        return v;
    endfunction

    localparam kg_vec_t EDGE_BITS = (kg_vec_t'(1) << TOP_BIT) | kg_vec_t'(1);

    localparam kg_vec_t R_TAPS  = kg_pattern(7, 3, 11) | kg_vec_t'(1);
    localparam kg_vec_t S_COMP0 = kg_pattern(5, 1, 9)  & ~EDGE_BITS;
    localparam kg_vec_t S_COMP1 = kg_pattern(3, 4, 7)  & ~EDGE_BITS;
    localparam kg_vec_t S_FB0   = kg_pattern(11, 2, 13);
    localparam kg_vec_t S_FB1   = kg_pattern(13, 5, 17);
    localparam kg_vec_t S_KEEP  = ~EDGE_BITS;
    localparam kg_vec_t S_TOP   = kg_vec_t'(1) << TOP_BIT;

endpackage

// File: rtl/kg_r_update.sv
module kg_r_update
    import kg_pkg::*;
(
    input  kg_vec_t r_i,
    input  kg_vec_t s_i,
    input  logic    mix_i,
    input  logic    ibit_i,
    output kg_vec_t r_o
);
    logic    ctl;
    logic    feed;
    logic    fb;
    kg_vec_t stepped;

    always_comb begin
        ctl     = s_i[R_CTL_SBIT] ^ r_i[R_CTL_RBIT];
        feed    = ibit_i ^ (s_i[MIX_SBIT] & mix_i);
        fb      = r_i[TOP_BIT] ^ feed;
        stepped = r_i << 1;
        if (fb) begin
            stepped = stepped ^ R_TAPS;
        end
        if (ctl) begin
            stepped = stepped ^ r_i;
        end
        r_o = stepped;
    end
endmodule

// File: rtl/kg_s_update.sv
module kg_s_update
    import kg_pkg::*;
(
    input  kg_vec_t s_i,
    input  kg_vec_t r_i,
    input  logic    ibit_i,
    output kg_vec_t s_o
);
    logic    ctl;
    logic    fb;
    kg_vec_t sh_up;
    kg_vec_t sh_dn;
    kg_vec_t mixed;

    always_comb begin
        ctl   = s_i[S_CTL_SBIT] ^ r_i[S_CTL_RBIT];
        fb    = s_i[TOP_BIT] ^ ibit_i;
        sh_up = s_i << 1;
        sh_dn = s_i >> 1;
        mixed = (sh_up ^ ((s_i ^ S_COMP0) & (sh_dn ^ S_COMP1))) & S_KEEP;
        if (s_i[NEXT_BIT]) begin
            mixed = mixed ^ S_TOP;
        end
        if (fb) begin
            mixed = mixed ^ (ctl ? S_FB1 : S_FB0);
        end
        s_o = mixed;
    end
endmodule

// File: rtl/kg_step.sv
module kg_step
    import kg_pkg::*;
(
    input  kg_state_t st_i,
    input  logic      mix_i,
    input  logic      ibit_i,
    output kg_state_t st_o,
    output logic      z_o
);
    kg_vec_t r_nx;
    kg_vec_t s_nx;

    kg_r_update u_r (
        .r_i   (st_i.r),
        .s_i   (st_i.s),
        .mix_i (mix_i),
        .ibit_i(ibit_i),
        .r_o   (r_nx)
    );

    kg_s_update u_s (
        .s_i   (st_i.s),
        .r_i   (st_i.r),
        .ibit_i(ibit_i),
        .s_o   (s_nx)
    );

    assign st_o = '{r: r_nx, s: s_nx};
    assign z_o  = st_i.r[0] ^ st_i.s[0];
endmodule

// File: rtl/kg2_core.sv
module kg2_core
    import kg_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               init_mode,
    input  logic               mix,
    input  logic               in_bit,
    input  logic               load,
    input  logic [KG_W-1:0]    r_load,
    input  logic [KG_W-1:0]    s_load,
    output logic [LANES-1:0]   ks,
    output logic               ks_valid
);
    kg_state_t st_q;
    kg_state_t chain [LANES+1];
    logic [LANES-1:0] z_v;
    kg_mode_e  mode;
    logic      mix_eff;
    logic      ibit_eff;

    assign mode     = kg_mode_e'(init_mode);
    assign mix_eff  = (mode == KG_INIT) & mix;
    assign ibit_eff = (mode == KG_INIT) & in_bit;
    assign chain[0] = st_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_first
            kg_step u_step (
                .st_i  (chain[g]),
                .mix_i (mix_eff),
                .ibit_i(ibit_eff),
                .st_o  (chain[g+1]),
                .z_o   (z_v[g])
            );
        end else begin : g_rest
            kg_step u_step (
                .st_i  (chain[g]),
                .mix_i (1'b0),
                .ibit_i(1'b0),
                .st_o  (chain[g+1]),
                .z_o   (z_v[g])
            );
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            ks       <= '0;
            ks_valid <= 1'b0;
        end else if (load) begin
            st_q     <= '{r: r_load, s: s_load};
            ks_valid <= 1'b0;
        end else if (en) begin
            if (mode == KG_INIT) begin
                st_q     <= chain[1];
                ks_valid <= 1'b0;
            end else begin
                st_q     <= chain[LANES];
                ks       <= z_v;
                ks_valid <= 1'b1;
            end
        end else begin
            ks_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/kg2_core_chk.sv
module kg2_core_chk
    import kg_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      en,
    input logic      init_mode,
    input logic      load,
    input kg_vec_t   r_load,
    input kg_vec_t   s_load,
    input logic      ks_valid,
    input kg_state_t st_q
);
    // R2: load writes both registers
    p_load_write_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (st_q.r == $past(r_load) && st_q.s == $past(s_load)));

    // R2: load suppresses valid
    p_load_novalid_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> !ks_valid);

    // R6: init steps produce no keystream
    p_init_novalid_r6: assert property (@(posedge clk) disable iff (rst)
        (en && init_mode && !load) |=> !ks_valid);

    // R9: enabled run cycle yields valid output
    p_run_valid_r9: assert property (@(posedge clk) disable iff (rst)
        (en && !init_mode && !load) |=> ks_valid);

    // R10: idle cycle holds state
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> ($stable(st_q) && !ks_valid));
endmodule

bind kg2_core kg2_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .init_mode(init_mode),
    .load     (load),
    .r_load   (r_load),
    .s_load   (s_load),
    .ks_valid (ks_valid),
    .st_q     (st_q)
);

// File: tb/kg2_core_tb.sv
module kg2_core_tb;
    import kg_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          en;
    logic          init_mode;
    logic          mix;
    logic          in_bit;
    logic          load;
    logic [159:0]  r_load;
    logic [159:0]  s_load;
    logic [1:0]    ks;
    logic          ks_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [159:0] rr;
    logic [159:0] ss;

    always #(CLK_PERIOD / 2) clk = ~clk;

    kg2_core u_dut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .init_mode(init_mode),
        .mix      (mix),
        .in_bit   (in_bit),
        .load     (load),
        .r_load   (r_load),
        .s_load   (s_load),
        .ks       (ks),
        .ks_valid (ks_valid)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // one independent generator step on the bench model
    task automatic ref_step(input logic mv, input logic iv, output logic z);
        logic [159:0] rn;
        logic [159:0] sn;
        logic cr, cs, ir, fr, fs;
        z  = rr[0] ^ ss[0];
        cr = ss[54] ^ rr[106];
        cs = ss[106] ^ rr[53];
        ir = iv ^ (ss[80] & mv);
        fr = rr[159] ^ ir;
        rn = {rr[158:0], 1'b0};
        if (fr) rn = rn ^ R_TAPS;
        if (cr) rn = rn ^ rr;
        fs = ss[159] ^ iv;
        sn = {ss[158:0], 1'b0} ^ ((ss ^ S_COMP0) & ({1'b0, ss[159:1]} ^ S_COMP1));
        sn[159] = ss[158];
        sn[0]   = 1'b0;
        if (fs) sn = sn ^ (cs ? S_FB1 : S_FB0);
        rr = rn;
        ss = sn;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        en = 1'b0; init_mode = 1'b0; mix = 1'b0; in_bit = 1'b0; load = 1'b0;
    endtask

    task automatic do_load(input logic [159:0] rv, input logic [159:0] sv, input logic with_run);
        load = 1'b1; r_load = rv; s_load = sv; en = with_run; init_mode = 1'b0;
        tick();
        load = 1'b0; en = 1'b0;
        rr = rv; ss = sv;
        check("R2 valid low after load", {7'd0, ks_valid}, 8'd0);
    endtask

    task automatic run_cycles(input int n, input logic mv, input logic iv, input string req);
        logic z0, z1;
        for (int k = 0; k < n; k++) begin
            en = 1'b1; init_mode = 1'b0; mix = mv; in_bit = iv;
            tick();
            ref_step(1'b0, 1'b0, z0);
            ref_step(1'b0, 1'b0, z1);
            check(req, {6'd0, ks}, {6'd0, z1, z0});
            check("R9 valid in run", {7'd0, ks_valid}, 8'd1);
        end
        idle_inputs();
    endtask

    task automatic t_reset();
        idle_inputs();
        r_load = '0; s_load = '0;
        rst = 1'b1;
        tick();
        check("R1 ks in reset", {6'd0, ks}, 8'd0);
        check("R1 valid in reset", {7'd0, ks_valid}, 8'd0);
        rst = 1'b0;
        tick();
        check("R1 ks after reset", {6'd0, ks}, 8'd0);
        check("R1 valid after reset", {7'd0, ks_valid}, 8'd0);
    endtask

    task automatic t_run_basic();
        do_load({5{32'hA5C3_1E97}}, {5{32'h3C69_D20B}}, 1'b0);
        run_cycles(40, 1'b0, 1'b0, "R3/R4/R8 run stream");
    endtask

    task automatic t_control_bits();
        logic [159:0] rv, sv;
        rv = '0; sv = '0;
        rv[106] = 1'b0; sv[54] = 1'b1;
        sv[106] = 1'b0; rv[53] = 1'b1;
        rv[0] = 1'b1; rv[159] = 1'b1; sv[158] = 1'b1; sv[12] = 1'b1;
        do_load(rv, sv, 1'b0);
        run_cycles(12, 1'b0, 1'b0, "R5 control bits both set");
    endtask

    task automatic t_run_ignores_inputs();
        do_load({5{32'h0F1E_2D3C}}, {5{32'h8877_6655}}, 1'b0);
        run_cycles(20, 1'b1, 1'b1, "R7 mix/in ignored in run");
    endtask

    task automatic t_init();
        logic zd;
        do_load({5{32'h1357_9BDF}}, {5{32'h2468_ACE0}}, 1'b0);
        for (int k = 0; k < 30; k++) begin
            en = 1'b1; init_mode = 1'b1;
            mix = (k % 3) != 0; in_bit = (k % 5) < 2;
            tick();
            ref_step(mix, in_bit, zd);
            check("R6 no valid in init", {7'd0, ks_valid}, 8'd0);
        end
        idle_inputs();
        run_cycles(20, 1'b0, 1'b0, "R6 stream after init");
    endtask

    task automatic t_pause();
        do_load({5{32'hDEAD_0123}}, {5{32'h4567_BEEF}}, 1'b0);
        run_cycles(5, 1'b0, 1'b0, "R8 before pause");
        for (int k = 0; k < 5; k++) begin
            en = 1'b0; mix = 1'b1; in_bit = 1'b1; init_mode = k[0];
            tick();
            check("R10 valid low idle", {7'd0, ks_valid}, 8'd0);
        end
        idle_inputs();
        run_cycles(10, 1'b0, 1'b0, "R10 resume continues");
    endtask

    task automatic t_load_vs_run();
        do_load({5{32'h7654_3210}}, {5{32'hFEDC_BA98}}, 1'b0);
        run_cycles(3, 1'b0, 1'b0, "R8 prior stream");
        do_load({5{32'h0BAD_F00D}}, {5{32'hC0FF_EE11}}, 1'b1);
        run_cycles(10, 1'b0, 1'b0, "R2 load wins over run");
    endtask

    initial begin
        rst = 1'b1;
        idle_inputs();
        r_load = '0; s_load = '0;
        t_reset();
        t_run_basic();
        t_control_bits();
        t_run_ignores_inputs();
        t_init();
        t_pause();
        t_load_vs_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule